// File: doc/BRIEF.md
# Operator-Selected Range Field Comparator

This block decides whether a 16-bit search value satisfies a one-sided range held in a single classification entry. The entry holds a bound and a 2-bit operator code. The code selects one of three tests: the search is at least the bound, the search is at most the bound, or the search equals the bound. A fourth code is reserved and never matches. The ternary prefix part of the same entry supplies an enable, and the range test can only report a hit when that enable is high.

The comparison works like a chain of range cells. Bits that are identical pass the decision down to the next lower bit. The most significant bit where search and bound differ settles the outcome, and that bit's direction is judged against the operator. The chain is split into three cascaded stages of 6, 5 and 5 bits, counted from the MSB. Each stage hands a decided flag and a match value to the stage below it. The result is registered. One cycle after a request, a valid strobe comes out together with the match flag.

Top module: `range_field_cmp`

## Requirements
- R1: With operator code 2'b10, the match flag is high exactly when the search value is greater than or equal to the bound, both read as unsigned.
- R2: With operator code 2'b01, the match flag is high exactly when the search value is less than or equal to the bound, both read as unsigned.
- R3: With operator code 2'b00, the match flag is high exactly when the search value equals the bound, and any differing bit fails the test.
- R4: Operator code 2'b11 never produces a match, whatever the search value and bound are.
- R5: When the search value and the bound are identical, codes 2'b10, 2'b01 and 2'b00 all match.
- R6: The outcome depends only on the highest differing bit, and the bits below it have no effect. For example, bound 0x000C against search 0x000A hits under 2'b01 and misses under 2'b10. Bound 0xFFFE against search 0xFFFF hits under 2'b10.
- R7: While the enable input is low, the match flag is low.
- R8: The valid strobe is high in the cycle after each cycle in which a request is presented, and low otherwise. The match flag belongs to that request and is low whenever the valid strobe is low.
- R9: After reset, the valid strobe and the match flag are both low.
- R10: The 6/5/5 stage split from the MSB gives the same result as a full-width compare when the first difference is at any bit position, including the bits on either side of each stage boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Search request for this cycle |
| enable_i | input | 1 | Ternary part of the entry matched |
| op_i | input | 2 | Operator code: 10 = at least, 01 = at most, 00 = equal, 11 = reserved |
| search_i | input | 16 | Search value |
| bound_i | input | 16 | Stored bound |
| match_o | output | 1 | Range test result for the previous cycle's request |
| valid_o | output | 1 | Strobe marking match_o as a result |

## Verification
The bench places a single differing bit at each of the 16 positions, including bits 10/9 and 5/4 on either side of the stage boundaries. A stage that failed to forward its upstream decision, or a scan that ran in the wrong direction, would let a lower bit override the real decider and flip the result. Equal operands are driven under every code: a design that treated "no difference" as "not decided" would miss them, and one that let the reserved code through would hit. Enable-low requests and idle cycles catch a match flag that leaks out without a qualifying request. A pseudo-random sweep compares every result against a plain integer compare.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    OP_EQ  = 2'b00,
    OP_LE  = 2'b01,
    OP_GE  = 2'b10,
    OP_RSV = 2'b11
  } op_code_t;

  // Verdict of a single differing bit position under an operator.
  function automatic logic judge_bit(input op_code_t op, input logic s, input logic b);
    case (op)
      OP_GE:   judge_bit = s & ~b;
      OP_LE:   judge_bit = ~s & b;
      default: judge_bit = 1'b0;
    endcase
  endfunction

  // Verdict when the whole field compared equal.
  function automatic logic judge_equal(input op_code_t op);
    judge_equal = (op != OP_RSV);
  endfunction

endpackage

// File: rtl/rfc_stage.sv
module rfc_stage
  import rfc_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] srch,
  input  logic [W-1:0] bound,
  input  op_code_t     op,
  input  logic         dec_in,
  input  logic         match_in,
  output logic         dec_out,
  output logic         match_out
);

  logic local_dec;
  logic local_match;

  // Scan from this stage's MSB downward; the first differing bit decides.
  always_comb begin
    local_dec   = 1'b0;
    local_match = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!local_dec && (srch[i] != bound[i])) begin
        local_dec   = 1'b1;
        local_match = judge_bit(op, srch[i], bound[i]);
      end
    end
  end

  assign dec_out   = dec_in | local_dec;
  assign match_out = dec_in ? match_in : local_match;

endmodule

// File: rtl/rfc_chain.sv
module rfc_chain
  import rfc_pkg::*;
#(
  parameter int FIELD_W    = 16,
  parameter int NUM_STAGES = 3
) (
  input  logic [FIELD_W-1:0]    srch,
  input  logic [FIELD_W-1:0]    bound,
  input  op_code_t              op,
  output logic [NUM_STAGES-1:0] stage_dec,
  output logic                  chain_match
);

  localparam int TAIL_W = FIELD_W / NUM_STAGES;
  localparam int HEAD_W = FIELD_W - (NUM_STAGES - 1) * TAIL_W;

  logic [NUM_STAGES:0] dec_c;
  logic [NUM_STAGES:0] match_c;

  assign dec_c[0]   = 1'b0;
  assign match_c[0] = 1'b0;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      rfc_stage #(.W(HEAD_W)) u_stage (
        .srch     (srch[FIELD_W-1 -: HEAD_W]),
        .bound    (bound[FIELD_W-1 -: HEAD_W]),
        .op       (op),
        .dec_in   (dec_c[k]),
        .match_in (match_c[k]),
        .dec_out  (dec_c[k+1]),
        .match_out(match_c[k+1])
      );
    end else begin : g_tail
      localparam int LSB = (NUM_STAGES - 1 - k) * TAIL_W;
      rfc_stage #(.W(TAIL_W)) u_stage (
        .srch     (srch[LSB +: TAIL_W]),
        .bound    (bound[LSB +: TAIL_W]),
        .op       (op),
        .dec_in   (dec_c[k]),
        .match_in (match_c[k]),
        .dec_out  (dec_c[k+1]),
        .match_out(match_c[k+1])
      );
    end
    assign stage_dec[k] = dec_c[k+1];
  end

  assign chain_match = match_c[NUM_STAGES];

endmodule

// File: rtl/rfc_verdict.sv
module rfc_verdict
  import rfc_pkg::*;
(
  input  op_code_t op,
  input  logic     enable,
  input  logic     decided,
  input  logic     chain_match,
  output logic     hit
);

  always_comb begin
    if (!enable)       hit = 1'b0;
    else if (decided)  hit = chain_match;
    else               hit = judge_equal(op);
  end

endmodule

// File: rtl/range_field_cmp.sv
module range_field_cmp
  import rfc_pkg::*;
#(
  parameter int FIELD_W    = 16,
  parameter int NUM_STAGES = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               enable_i,
  input  logic [1:0]         op_i,
  input  logic [FIELD_W-1:0] search_i,
  input  logic [FIELD_W-1:0] bound_i,
  output logic               match_o,
  output logic               valid_o
);

  op_code_t              op;
  logic [NUM_STAGES-1:0] stage_decided;
  logic                  chain_match;
  logic                  resolved_hit;
  logic                  match_q;
  logic                  valid_q;

  assign op = op_code_t'(op_i);

  rfc_chain #(.FIELD_W(FIELD_W), .NUM_STAGES(NUM_STAGES)) u_chain (
    .srch       (search_i),
    .bound      (bound_i),
    .op         (op),
    .stage_dec  (stage_decided),
    .chain_match(chain_match)
  );

  rfc_verdict u_verdict (
    .op         (op),
    .enable     (enable_i),
    .decided    (stage_decided[NUM_STAGES-1]),
    .chain_match(chain_match),
    .hit        (resolved_hit)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      match_q <= req_i & resolved_hit;
    end
  end

  assign match_o = match_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/range_field_cmp_chk.sv
module range_field_cmp_chk #(
  parameter int FIELD_W    = 16,
  parameter int NUM_STAGES = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  enable_i,
  input logic [1:0]            op_i,
  input logic [FIELD_W-1:0]    search_i,
  input logic [FIELD_W-1:0]    bound_i,
  input logic                  match_o,
  input logic                  valid_o,
  input logic [NUM_STAGES-1:0] stage_decided
);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R8
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R8
  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> valid_o); // R8
  AST_DISABLED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !enable_i) |=> !match_o); // R7
  AST_RESERVED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b11) |=> !match_o); // R4
  AST_EQUAL_OPERANDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && enable_i && op_i != 2'b11 && search_i == bound_i) |=> match_o); // R5
  AST_EQ_DIFF_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b00 && search_i != bound_i) |=> !match_o); // R3
  AST_GE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && enable_i && op_i == 2'b10) |=> (match_o == ($past(search_i) >= $past(bound_i)))); // R1
  AST_LE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && enable_i && op_i == 2'b01) |=> (match_o == ($past(search_i) <= $past(bound_i)))); // R2
  AST_CHAIN_DECIDES_ON_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_decided[NUM_STAGES-1] == (search_i != bound_i)); // R10

  for (genvar k = 0; k + 1 < NUM_STAGES; k++) begin : g_mono
    AST_DECIDED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_decided[k] |-> stage_decided[k+1]); // R6
  end

endmodule

bind range_field_cmp range_field_cmp_chk #(.FIELD_W(FIELD_W), .NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .enable_i     (enable_i),
  .op_i         (op_i),
  .search_i     (search_i),
  .bound_i      (bound_i),
  .match_o      (match_o),
  .valid_o      (valid_o),
  .stage_decided(stage_decided)
);

// File: tb/range_field_cmp_tb.sv
module range_field_cmp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic         enable_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] search_i = '0;
  logic [W-1:0] bound_i = '0;
  logic         match_o;
  logic         valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  range_field_cmp u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .enable_i(enable_i),
    .op_i    (op_i),
    .search_i(search_i),
    .bound_i (bound_i),
    .match_o (match_o),
    .valid_o (valid_o)
  );

  // Reference: plain unsigned integer comparison per operator code.
  function automatic logic model(input logic [W-1:0] s, input logic [W-1:0] b,
                                 input logic [1:0] op, input logic en);
    int unsigned si = s;
    int unsigned bi = b;
    if (!en) return 1'b0;
    case (op)
      2'b10:   return si >= bi;
      2'b01:   return si <= bi;
      2'b00:   return si == bi;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [W-1:0] s, input logic [W-1:0] b,
                       input logic [1:0] op, input logic en);
    @(negedge clk_i);
    req_i    = 1'b1;
    enable_i = en;
    op_i     = op;
    search_i = s;
    bound_i  = b;
    exp_q.push_back(model(s, b, op, en));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_i = 1'b0;
    end
  endtask

  // Monitor: sample just after each edge, pop the scoreboard on each strobe.
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni) begin
        if (valid_o) begin
          if (exp_q.size() == 0) begin
            check("R8 unexpected strobe", valid_o, 1'b0);
          end else begin
            string t;
            logic e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, match_o, e);
          end
        end else if (match_o) begin
          check("R8 match without strobe", match_o, 1'b0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk_i);
    #1;
    check("R9 valid after reset", valid_o, 1'b0);
    check("R9 match after reset", match_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    check("R9 idle valid", valid_o, 1'b0);

    // Documented examples
    drive("R6 R2 bound C search A at-most", 16'h000A, 16'h000C, 2'b01, 1'b1);
    drive("R6 R1 bound C search A at-least", 16'h000A, 16'h000C, 2'b10, 1'b1);
    drive("R6 R1 bound FFFE search FFFF at-least", 16'hFFFF, 16'hFFFE, 2'b10, 1'b1);
    drive("R6 R2 bound FFFE search FFFF at-most", 16'hFFFF, 16'hFFFE, 2'b01, 1'b1);
    drive("R6 low bits ignored", 16'h8000, 16'h7FFF, 2'b10, 1'b1);
    drive("R6 low bits ignored at-most", 16'h7FFF, 16'h8000, 2'b01, 1'b1);

    // Equal operands under each code
    drive("R5 equal at-least", 16'h1234, 16'h1234, 2'b10, 1'b1);
    drive("R5 equal at-most", 16'h1234, 16'h1234, 2'b01, 1'b1);
    drive("R5 R3 equal eq", 16'h1234, 16'h1234, 2'b00, 1'b1);
    drive("R4 equal reserved", 16'h1234, 16'h1234, 2'b11, 1'b1);
    drive("R4 reserved greater", 16'hFFFF, 16'h0000, 2'b11, 1'b1);
    drive("R4 reserved less", 16'h0000, 16'hFFFF, 2'b11, 1'b1);
    drive("R3 eq lsb differs", 16'h1235, 16'h1234, 2'b00, 1'b1);
    drive("R3 eq msb differs", 16'h9234, 16'h1234, 2'b00, 1'b1);

    // Enable low
    drive("R7 disabled equal", 16'h4444, 16'h4444, 2'b10, 1'b0);
    drive("R7 disabled at-least", 16'hFFFF, 16'h0001, 2'b10, 1'b0);
    drive("R7 disabled at-most", 16'h0001, 16'hFFFF, 2'b01, 1'b0);

    // Interleaved idle cycles
    idle(3);
    check("R8 strobe drops when idle", valid_o, 1'b0);
    drive("R8 request after idle", 16'h0100, 16'h00FF, 2'b10, 1'b1);
    idle(1);

    // Single differing bit at every position, both directions
    for (int p = 0; p < W; p++) begin
      logic [W-1:0] b;
      logic [W-1:0] s;
      b = 16'h5A5A;
      s = b ^ (16'(1) << p);
      drive("R10 single bit diff at-least", s, b, 2'b10, 1'b1);
      drive("R10 single bit diff at-most", s, b, 2'b01, 1'b1);
      drive("R10 single bit diff at-least swapped", b, s, 2'b10, 1'b1);
      drive("R10 single bit diff at-most swapped", b, s, 2'b01, 1'b1);
    end

    // Boundary decider with noisy lower bits opposing it
    for (int p = 1; p < W; p++) begin
      logic [W-1:0] hi;
      hi = 16'h0000 | (16'(1) << p);
      drive("R10 R1 boundary decider", hi, hi - 16'd1, 2'b10, 1'b1);
      drive("R10 R2 boundary decider", hi - 16'd1, hi, 2'b01, 1'b1);
    end

    // Pseudo-random sweep
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] s;
      logic [W-1:0] b;
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
      s = lf[15:0];
      b = (lf[20:18] == 3'd0) ? lf[15:0] : {lf[31:24], lf[7:0] ^ lf[23:16]};
      drive((lf[17:16] == 2'b10) ? "R1 random" :
            (lf[17:16] == 2'b01) ? "R2 random" :
            (lf[17:16] == 2'b00) ? "R3 random" : "R4 random",
            s, b, lf[17:16], lf[22:21] != 2'b00);
    end

    idle(4);
    check("R8 all requests answered", 1'(exp_q.size() == 0), 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule